// File: doc/BRIEF.md
# Reset Source Controller with Cause Flags

This block takes several reset requests and turns them into one internal reset pulse of a fixed length. The requests are a low-voltage detector, a voltage-threshold configuration register that holds an undefined code, a watchdog expiry, and a magic byte written to a programming control register. For each request it sets a sticky cause flag in a status register. The CPU can read these flags after the restart and clear them. Hardware never clears them.

The reset pulse is stretched by one of two counts. The count depends on whether the core was running or asleep when the request arrived. A watchdog expiry also sets a timeout flag, and if the core was asleep it sets a power-down flag as well. Software sees the block through a small four-address register port. The block's own registers are cleared only by the power-on reset. The internal reset it generates does not clear them.

Top module: `rst_cause_ctrl`

## Requirements
- R1: Address 0 is the cause register. Bits 7..4 read 0. Bit 3 is the magic-write cause, bit 2 the low-voltage cause, bit 1 the bad-threshold-code cause and bit 0 the watchdog cause. After power-on, bits 3, 1 and 0 are 0 and bit 2 equals parameter LVF_INIT.
- R2: Cause flags and the flags at address 3 are sticky. A write to their address clears every flag whose data bit is 0. A data bit of 1 leaves its flag unchanged. If a hardware set and a software clear of the same flag land on the same edge, the set wins.
- R3: lvd_trip high at a rising edge sets cause bit 2 and starts a reset stretch.
- R4: Address 1 holds the 8-bit threshold code. Its power-on value is CFG_CODES[7:0], and the valid codes are the four bytes of CFG_CODES (default 0x33, 0x66, 0x99, 0xCC). If the register holds any other value, then at the next edge cause bit 1 sets, a stretch starts, and the register returns to CFG_CODES[7:0]. That restore takes priority over a write on the same edge.
- R5: Writing exactly MAGIC (0x55) to address 2 sets cause bit 3 and starts a stretch. Any other value written there has no effect. Address 2 reads 0.
- R6: wdt_expire high at an edge sets cause bit 0 and the timeout flag (address 3, bit 0). If core_sleep is also high at that edge, it sets the power-down flag (address 3, bit 1). Address 3 bits 7..2 read 0.
- R7: sys_rst is low after power-on. After a triggering edge, sys_rst is high for exactly RUN_CYC cycles, or SLEEP_CYC cycles if core_sleep was high at that edge. A new trigger during a stretch restarts the count.
- R8: Sources that trigger on the same edge all set their flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| lvd_trip | input | 1 | Low-voltage condition from the detector |
| wdt_expire | input | 1 | Watchdog expiry |
| core_sleep | input | 1 | Core is in sleep or idle |
| sys_rst | output | 1 | Stretched internal reset |

## Verification
The bench sets RUN_CYC to 5 and SLEEP_CYC to 9 and keeps the default code list. With these values, both stretch lengths can be counted edge by edge. A reload partway through a stretch can be seen in a few cycles. The differing lengths show at once whether the sleep state picked the right count. The invalid-code path is exercised with a write of a byte outside the default list, including the restore to 0x33.

// File: rtl/rst_cause_ctrl.sv
module rst_cause_ctrl #(
  parameter int          RUN_CYC   = 16,
  parameter int          SLEEP_CYC = 64,
  parameter logic [31:0] CFG_CODES = 32'hCC_99_66_33,
  parameter logic [7:0]  MAGIC     = 8'h55,
  parameter logic        LVF_INIT  = 1'b0
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       reg_we,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       lvd_trip,
  input  logic       wdt_expire,
  input  logic       core_sleep,
  output logic       sys_rst
);
  localparam int NCODE = 4;
  localparam int MAXC  = (RUN_CYC > SLEEP_CYC) ? RUN_CYC : SLEEP_CYC;
  localparam int CW    = $clog2(MAXC + 1);
  localparam logic [CW-1:0] RUN_L   = CW'(RUN_CYC);
  localparam logic [CW-1:0] SLEEP_L = CW'(SLEEP_CYC);

  logic [3:0]       cause;
  logic [7:0]       vcfg;
  logic             to_f, pd_f;
  logic [CW-1:0]    cnt;
  logic [NCODE-1:0] hit;

  genvar gi;
  generate
    for (gi = 0; gi < NCODE; gi++) begin : g_code
      assign hit[gi] = (vcfg == CFG_CODES[8*gi +: 8]);
    end
  endgenerate

  wire cfg_bad   = ~|hit;
  wire wr_cause  = reg_we && (reg_addr == 2'd0);
  wire wr_cfg    = reg_we && (reg_addr == 2'd1);
  wire wr_core   = reg_we && (reg_addr == 2'd3);
  wire magic_hit = reg_we && (reg_addr == 2'd2) && (reg_wdata == MAGIC);
  wire [3:0] set_v = {magic_hit, lvd_trip, cfg_bad, wdt_expire};
  wire trig = |set_v;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) cause <= {1'b0, LVF_INIT, 2'b00};
    else        cause <= (wr_cause ? (cause & reg_wdata[3:0]) : cause) | set_v;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)       vcfg <= CFG_CODES[7:0];
    else if (cfg_bad) vcfg <= CFG_CODES[7:0];
    else if (wr_cfg)  vcfg <= reg_wdata;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      to_f <= 1'b0;
      pd_f <= 1'b0;
    end else begin
      to_f <= (wr_core ? (to_f & reg_wdata[0]) : to_f) | wdt_expire;
      pd_f <= (wr_core ? (pd_f & reg_wdata[1]) : pd_f) | (wdt_expire & core_sleep);
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)          cnt <= '0;
    else if (trig)       cnt <= core_sleep ? SLEEP_L : RUN_L;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign sys_rst = (cnt != '0);

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {4'h0, cause};
      2'd1:    reg_rdata = vcfg;
      2'd3:    reg_rdata = {6'h00, pd_f, to_f};
      default: reg_rdata = 8'h00;
    endcase
  end

  p_hi_zero_r1: assert property (@(posedge clk) disable iff (!por_n)
    (reg_addr != 2'd1) |-> (reg_rdata[7:4] == 4'h0));

  p_sticky_r2: assert property (@(posedge clk) disable iff (!por_n)
    (|($past(cause) & ~cause)) |-> $past(wr_cause));

  p_cfg_recover_r4: assert property (@(posedge clk) disable iff (!por_n)
    cfg_bad |=> !cfg_bad);

  p_pd_sleep_r6: assert property (@(posedge clk) disable iff (!por_n)
    $rose(pd_f) |-> $past(wdt_expire && core_sleep));

  p_rst_cause_r7: assert property (@(posedge clk) disable iff (!por_n)
    $rose(sys_rst) |-> $past(trig));
endmodule

// File: tb/rst_cause_ctrl_tb.sv
module rst_cause_ctrl_tb;
  localparam int RUN = 5;
  localparam int SLP = 9;
  localparam logic [31:0] CODES = 32'hCC_99_66_33;

  logic clk = 0, por_n = 0, reg_we = 0, lvd = 0, wdt = 0, slp = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic sys_rst;
  int total = 0, bad = 0, cyc = 0;

  rst_cause_ctrl #(.RUN_CYC(RUN), .SLEEP_CYC(SLP), .CFG_CODES(CODES), .MAGIC(8'h55),
                   .LVF_INIT(1'b0)) u_dut (
    .clk(clk), .por_n(por_n), .reg_we(reg_we), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata), .lvd_trip(lvd), .wdt_expire(wdt), .core_sleep(slp), .sys_rst(sys_rst));

  always #2.5 clk = ~clk;

  logic [3:0] m_cause = 4'h0;
  logic [7:0] m_cfg = 8'h33;
  logic m_to = 0, m_pd = 0;
  int m_cnt = 0;

  function automatic bit valid_code(input logic [7:0] v);
    return v == 8'h33 || v == 8'h66 || v == 8'h99 || v == 8'hCC;
  endfunction

  always @(posedge clk) begin
    if (!por_n) begin
      m_cause = 4'h0; m_cfg = 8'h33; m_to = 0; m_pd = 0; m_cnt = 0;
    end else begin
      bit bad_cfg, mag, any;
      bad_cfg = !valid_code(m_cfg);
      mag = reg_we && addr == 2 && wdata == 8'h55;
      any = bad_cfg || mag || lvd || wdt;
      if (reg_we && addr == 0) m_cause = m_cause & wdata[3:0];
      if (mag) m_cause[3] = 1;
      if (lvd) m_cause[2] = 1;
      if (bad_cfg) m_cause[1] = 1;
      if (wdt) m_cause[0] = 1;
      if (bad_cfg) m_cfg = 8'h33;
      else if (reg_we && addr == 1) m_cfg = wdata;
      if (reg_we && addr == 3) begin m_to = m_to & wdata[0]; m_pd = m_pd & wdata[1]; end
      if (wdt) m_to = 1;
      if (wdt && slp) m_pd = 1;
      if (any) m_cnt = slp ? SLP : RUN;
      else if (m_cnt > 0) m_cnt--;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    logic [7:0] e;
    string tg;
    chk(sys_rst == (m_cnt != 0), "R7 sys_rst per-cycle", sys_rst, m_cnt != 0);
    case (addr)
      0: begin e = {4'h0, m_cause}; tg = "R2 cause per-cycle"; end
      1: begin e = m_cfg; tg = "R4 cfg per-cycle"; end
      3: begin e = {6'h0, m_pd, m_to}; tg = "R6 core flags per-cycle"; end
      default: begin e = 8'h00; tg = "R5 addr2 per-cycle"; end
    endcase
    chk(rdata == e, tg, rdata, e);
  end

  task automatic step(); @(posedge clk); #1; endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1 reg_we = 1; addr = a; wdata = d;
    step(); reg_we = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a; #0.5 d = rdata;
  endtask

  task automatic pulse(input logic l, input logic w, input logic s);
    @(posedge clk); #1 lvd = l; wdt = w; slp = s;
    step(); lvd = 0; wdt = 0; slp = 0;
  endtask

  task automatic hold_len(output int n);
    n = 0;
    while (sys_rst && n < 100) begin n++; step(); end
  endtask

  initial begin
    logic [7:0] d;
    int n;
    repeat (3) step();
    rd(0, d); chk(d == 8'h00, "R1 cause after power-on", d, 8'h00);
    rd(1, d); chk(d == 8'h33, "R4 cfg after power-on", d, 8'h33);
    chk(sys_rst == 0, "R7 no reset during power-on", sys_rst, 0);
    por_n = 1;
    repeat (2) step();
    chk(sys_rst == 0, "R7 idle after power-on", sys_rst, 0);

    addr = 0;
    pulse(1, 0, 0); hold_len(n);
    chk(n == RUN, "R7 run stretch after low-voltage", n, RUN);
    rd(0, d); chk(d == 8'h04, "R3 low-voltage cause", d, 8'h04);
    wr(0, 8'hFF); rd(0, d); chk(d == 8'h04, "R2 write of ones ignored", d, 8'h04);
    wr(0, 8'h00); rd(0, d); chk(d == 8'h00, "R2 write of zero clears", d, 8'h00);

    wr(1, 8'h66); rd(1, d); chk(d == 8'h66, "R4 valid code stored", d, 8'h66);
    chk(sys_rst == 0, "R4 valid code no reset", sys_rst, 0);
    wr(1, 8'h12);
    chk(sys_rst == 0, "R4 invalid code reset one cycle later", sys_rst, 0);
    step(); hold_len(n);
    chk(n == RUN, "R4 invalid code stretch", n, RUN);
    rd(1, d); chk(d == 8'h33, "R4 code restored", d, 8'h33);
    rd(0, d); chk(d == 8'h02, "R4 bad code cause", d, 8'h02);
    wr(0, 8'h00);

    wr(2, 8'h54); step();
    chk(sys_rst == 0, "R5 non-magic write no reset", sys_rst, 0);
    rd(0, d); chk(d == 8'h00, "R5 non-magic no flag", d, 8'h00);
    wr(2, 8'h55); hold_len(n);
    chk(n == RUN, "R5 magic write stretch", n, RUN);
    rd(2, d); chk(d == 8'h00, "R5 addr2 reads zero", d, 8'h00);
    rd(0, d); chk(d == 8'h08, "R5 magic cause", d, 8'h08);
    wr(0, 8'h00);

    pulse(0, 1, 0); hold_len(n);
    chk(n == RUN, "R7 awake watchdog stretch", n, RUN);
    rd(3, d); chk(d == 8'h01, "R6 timeout without power-down", d, 8'h01);
    wr(3, 8'h00);
    pulse(0, 1, 1); hold_len(n);
    chk(n == SLP, "R7 sleep watchdog stretch", n, SLP);
    rd(3, d); chk(d == 8'h03, "R6 timeout and power-down", d, 8'h03);
    rd(0, d); chk(d == 8'h01, "R6 watchdog cause", d, 8'h01);
    wr(3, 8'hFE); rd(3, d); chk(d == 8'h02, "R2 core flag partial clear", d, 8'h02);
    wr(3, 8'h00); wr(0, 8'h00);

    @(posedge clk); #1 reg_we = 1; addr = 2; wdata = 8'h55; lvd = 1; wdt = 1;
    step(); reg_we = 0; lvd = 0; wdt = 0;
    rd(0, d); chk(d == 8'h0D, "R8 simultaneous sources", d, 8'h0D);
    hold_len(n);
    @(posedge clk); #1 reg_we = 1; addr = 0; wdata = 8'h00; lvd = 1;
    step(); reg_we = 0; lvd = 0;
    rd(0, d); chk(d == 8'h04, "R2 set wins over clear", d, 8'h04);
    hold_len(n);

    pulse(1, 0, 0); step();
    @(posedge clk); #1 lvd = 1; step(); lvd = 0;
    hold_len(n);
    chk(n == RUN, "R7 reload during stretch", n, RUN);
    repeat (3) step();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule